// File: doc/BRIEF.md
# Second-Level Cache Enable Sequencer

This block brings a second-level cache online without breaking coherence with the first-level caches. It keeps its own copy of a processor feature word and of the two first-level enable bits (data and instruction). When told to start, it captures those values, forces the prefetch-disable bit on, and checks whether the second-level enable bit is already set. If that bit is already set, it finishes at once.

Otherwise the second-level cache may only be switched on while both first-level caches are off. The block flushes and turns off the data cache if it was on, and turns off and invalidates the instruction cache if it was on. It then invalidates the whole second-level cache and sets the enable bit. Last, it turns back on only the first-level caches it turned off, the instruction cache first. Every maintenance operation goes out as a one-cycle request, and the block waits for the matching completion input before it moves on. The updated copies on the outputs are written back by the surrounding logic.

Top module: `l2_enable_seq`

## Requirements
- R1: After reset the feature copy and both first-level enable outputs are zero, no request is raised and `done_o` is low.
- R2: A `start_i` seen while idle captures `feat_in_i`, `dc_en_in_i` and `ic_en_in_i`, and the captured feature word always has the prefetch-disable bit (bit 24 by default) set.
- R3: If the enable bit (bit 22 by default) is set in the captured feature word, no request is raised, both first-level enables keep their captured values, and `done_o` pulses.
- R4: If the data cache was on, `dc_flush_req_o` is raised, and `dc_en_o` goes low only after `dc_flush_done_i` answers it. If the data cache was off, no flush is requested.
- R5: If the instruction cache was on, `ic_en_o` goes low no later than `ic_inv_req_o` is raised. If the instruction cache was off, no invalidation of it is requested.
- R6: `l2_inv_req_o` is raised only while both first-level enables are low, and the enable bit of the feature copy is set only after `l2_inv_done_i` answers it.
- R7: After the enable bit is set, `ic_en_o` is restored first and `dc_en_o` second, each only if this run turned it off.
- R8: Each request output is high for exactly one cycle, at most one is high at a time, and a completion input is ignored unless its own request is outstanding.
- R9: `start_i` is ignored while a sequence runs, and `done_o` is high for exactly one cycle as the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sequence (honoured only while idle) |
| feat_in_i | input | FEAT_W | Current feature word, captured at start |
| dc_en_in_i | input | 1 | Current data-cache enable, captured at start |
| ic_en_in_i | input | 1 | Current instruction-cache enable, captured at start |
| feat_o | output | FEAT_W | Working copy of the feature word |
| dc_en_o | output | 1 | Working data-cache enable |
| ic_en_o | output | 1 | Working instruction-cache enable |
| dc_flush_req_o | output | 1 | One-cycle request: flush the data cache |
| ic_inv_req_o | output | 1 | One-cycle request: invalidate the instruction cache |
| l2_inv_req_o | output | 1 | One-cycle request: invalidate the whole second-level cache |
| dc_flush_done_i | input | 1 | Data-cache flush finished |
| ic_inv_done_i | input | 1 | Instruction-cache invalidation finished |
| l2_inv_done_i | input | 1 | Second-level invalidation finished |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
Some properties are checked on every cycle: requests are single pulses and never overlap, the second-level invalidation and the enable-bit rise happen only while both first-level caches are off, the instruction-cache invalidation happens only after that cache is disabled, and the finishing pulse is one cycle long with both feature bits set. Other behaviour depends on the history of a run, so only the bench's scenarios can show it. This covers which caches get disabled and restored for each starting combination, the order of restores, the skip when the cache is already enabled, and the fact that stray completions and a second start leave the sequence unchanged.

// File: rtl/l2seq_pkg.sv
package l2seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CHECK,
      ST_WAIT_DFL,
      ST_ICHECK,
      ST_WAIT_IINV,
      ST_WAIT_L2,
      ST_REST_I,
      ST_REST_D,
      ST_FINISH
   } seq_st_e;

   localparam int unsigned CMD_N     = 3;
   localparam int unsigned CMD_DFL   = 0;
   localparam int unsigned CMD_IINV  = 1;
   localparam int unsigned CMD_L2INV = 2;

endpackage

// File: rtl/l2seq_cmd.sv
// One maintenance command port: registered request pulse plus outstanding tracker.
module l2seq_cmd (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_i,
   input  logic done_i,
   output logic req_o,
   output logic ack_o
);
   logic req_q;
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         req_q <= issue_i;
         if (issue_i)
            pend_q <= 1'b1;
         else if (pend_q && done_i)
            pend_q <= 1'b0;
      end
   end

   assign req_o = req_q;
   // completion only counts while this command is outstanding
   assign ack_o = pend_q & done_i;
endmodule

// File: rtl/l2seq_shadow.sv
// Working copies of the feature word and first-level enables.
module l2seq_shadow #(
   parameter int unsigned FEAT_W = 32,
   parameter int unsigned PF_BIT = 24,
   parameter int unsigned EN_BIT = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [FEAT_W-1:0] feat_in_i,
   input  logic              dc_in_i,
   input  logic              ic_in_i,
   input  logic              dc_clr_i,
   input  logic              ic_clr_i,
   input  logic              dc_set_i,
   input  logic              ic_set_i,
   input  logic              en_set_i,
   output logic [FEAT_W-1:0] feat_o,
   output logic              dc_o,
   output logic              ic_o
);
   localparam logic [FEAT_W-1:0] ONE     = {{(FEAT_W-1){1'b0}}, 1'b1};
   localparam logic [FEAT_W-1:0] PF_MASK = ONE << PF_BIT;
   localparam logic [FEAT_W-1:0] EN_MASK = ONE << EN_BIT;

   logic [FEAT_W-1:0] feat_q;
   logic              dc_q;
   logic              ic_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         feat_q <= '0;
         dc_q   <= 1'b0;
         ic_q   <= 1'b0;
      end else begin
         if (load_i)
            feat_q <= feat_in_i | PF_MASK;
         else if (en_set_i)
            feat_q <= feat_q | EN_MASK;

         if (load_i)
            dc_q <= dc_in_i;
         else if (dc_clr_i)
            dc_q <= 1'b0;
         else if (dc_set_i)
            dc_q <= 1'b1;

         if (load_i)
            ic_q <= ic_in_i;
         else if (ic_clr_i)
            ic_q <= 1'b0;
         else if (ic_set_i)
            ic_q <= 1'b1;
      end
   end

   assign feat_o = feat_q;
   assign dc_o   = dc_q;
   assign ic_o   = ic_q;
endmodule

// File: rtl/l2seq_ctrl.sv
// Sequencing FSM.
module l2seq_ctrl
   import l2seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             en_bit_i,
   input  logic             dc_en_i,
   input  logic             ic_en_i,
   input  logic [CMD_N-1:0] ack_i,
   output logic [CMD_N-1:0] issue_o,
   output logic             load_o,
   output logic             dc_clr_o,
   output logic             ic_clr_o,
   output logic             dc_set_o,
   output logic             ic_set_o,
   output logic             en_set_o,
   output logic             busy_o,
   output logic             done_o
);
   seq_st_e st_q, st_d;
   logic    did_dc_q;
   logic    did_ic_q;

   always_comb begin
      st_d     = st_q;
      issue_o  = '0;
      load_o   = 1'b0;
      dc_clr_o = 1'b0;
      ic_clr_o = 1'b0;
      dc_set_o = 1'b0;
      ic_set_o = 1'b0;
      en_set_o = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               load_o = 1'b1;
               st_d   = ST_CHECK;
            end
         end
         ST_CHECK: begin
            if (en_bit_i)
               st_d = ST_FINISH;
            else if (dc_en_i) begin
               issue_o[CMD_DFL] = 1'b1;
               st_d             = ST_WAIT_DFL;
            end else
               st_d = ST_ICHECK;
         end
         ST_WAIT_DFL: begin
            if (ack_i[CMD_DFL]) begin
               dc_clr_o = 1'b1;
               st_d     = ST_ICHECK;
            end
         end
         ST_ICHECK: begin
            if (ic_en_i) begin
               ic_clr_o          = 1'b1;
               issue_o[CMD_IINV] = 1'b1;
               st_d              = ST_WAIT_IINV;
            end else begin
               issue_o[CMD_L2INV] = 1'b1;
               st_d               = ST_WAIT_L2;
            end
         end
         ST_WAIT_IINV: begin
            if (ack_i[CMD_IINV]) begin
               issue_o[CMD_L2INV] = 1'b1;
               st_d               = ST_WAIT_L2;
            end
         end
         ST_WAIT_L2: begin
            if (ack_i[CMD_L2INV]) begin
               en_set_o = 1'b1;
               st_d     = ST_REST_I;
            end
         end
         ST_REST_I: begin
            ic_set_o = did_ic_q;
            st_d     = ST_REST_D;
         end
         ST_REST_D: begin
            dc_set_o = did_dc_q;
            st_d     = ST_FINISH;
         end
         ST_FINISH: st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         did_dc_q <= 1'b0;
         did_ic_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (load_o) begin
            did_dc_q <= 1'b0;
            did_ic_q <= 1'b0;
         end else begin
            if (dc_clr_o) did_dc_q <= 1'b1;
            if (ic_clr_o) did_ic_q <= 1'b1;
         end
      end
   end

   assign busy_o = (st_q != ST_IDLE);
   assign done_o = (st_q == ST_FINISH);
endmodule

// File: rtl/l2_enable_seq.sv
module l2_enable_seq
   import l2seq_pkg::*;
#(
   parameter int unsigned FEAT_W = 32,
   parameter int unsigned PF_BIT = 24,
   parameter int unsigned EN_BIT = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [FEAT_W-1:0] feat_in_i,
   input  logic              dc_en_in_i,
   input  logic              ic_en_in_i,
   output logic [FEAT_W-1:0] feat_o,
   output logic              dc_en_o,
   output logic              ic_en_o,
   output logic              dc_flush_req_o,
   output logic              ic_inv_req_o,
   output logic              l2_inv_req_o,
   input  logic              dc_flush_done_i,
   input  logic              ic_inv_done_i,
   input  logic              l2_inv_done_i,
   output logic              done_o
);
   if (FEAT_W < 2) begin : g_bad_width
      $error("l2_enable_seq: FEAT_W must be at least 2");
   end
   if (PF_BIT >= FEAT_W || EN_BIT >= FEAT_W) begin : g_bad_bitpos
      $error("l2_enable_seq: feature bit position outside the word");
   end
   if (PF_BIT == EN_BIT) begin : g_bad_overlap
      $error("l2_enable_seq: prefetch and enable bits must differ");
   end

   logic [CMD_N-1:0] issue;
   logic [CMD_N-1:0] ack;
   logic [CMD_N-1:0] req;
   logic [CMD_N-1:0] cmd_done;
   logic             load, dc_clr, ic_clr, dc_set, ic_set, en_set, busy;

   assign cmd_done[CMD_DFL]   = dc_flush_done_i;
   assign cmd_done[CMD_IINV]  = ic_inv_done_i;
   assign cmd_done[CMD_L2INV] = l2_inv_done_i;

   for (genvar k = 0; k < CMD_N; k++) begin : g_cmd
      l2seq_cmd u_cmd (
         .clk     (clk),
         .rst_n   (rst_n),
         .issue_i (issue[k]),
         .done_i  (cmd_done[k]),
         .req_o   (req[k]),
         .ack_o   (ack[k])
      );
   end

   l2seq_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .en_bit_i (feat_o[EN_BIT]),
      .dc_en_i  (dc_en_o),
      .ic_en_i  (ic_en_o),
      .ack_i    (ack),
      .issue_o  (issue),
      .load_o   (load),
      .dc_clr_o (dc_clr),
      .ic_clr_o (ic_clr),
      .dc_set_o (dc_set),
      .ic_set_o (ic_set),
      .en_set_o (en_set),
      .busy_o   (busy),
      .done_o   (done_o)
   );

   l2seq_shadow #(
      .FEAT_W (FEAT_W),
      .PF_BIT (PF_BIT),
      .EN_BIT (EN_BIT)
   ) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .feat_in_i (feat_in_i),
      .dc_in_i   (dc_en_in_i),
      .ic_in_i   (ic_en_in_i),
      .dc_clr_i  (dc_clr),
      .ic_clr_i  (ic_clr),
      .dc_set_i  (dc_set),
      .ic_set_i  (ic_set),
      .en_set_i  (en_set),
      .feat_o    (feat_o),
      .dc_o      (dc_en_o),
      .ic_o      (ic_en_o)
   );

   assign dc_flush_req_o = req[CMD_DFL];
   assign ic_inv_req_o   = req[CMD_IINV];
   assign l2_inv_req_o   = req[CMD_L2INV];
endmodule

// File: rtl/l2_enable_seq_chk.sv
module l2_enable_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic pf_bit,
   input logic en_bit,
   input logic dc_en,
   input logic ic_en,
   input logic dfl_req,
   input logic iinv_req,
   input logic l2inv_req,
   input logic done
);
   AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !done && !dfl_req && !iinv_req && !l2inv_req); // R1
   AST_DONE_PF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pf_bit); // R2
   AST_IINV_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      iinv_req |-> !ic_en); // R5
   AST_L2INV_L1_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      l2inv_req |-> !dc_en && !ic_en); // R6
   AST_EN_RISE_L1_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(en_bit) && $past(busy)) |-> !dc_en && !ic_en); // R6
   AST_DONE_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> en_bit); // R6
   AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dfl_req, iinv_req, l2inv_req})); // R8
   AST_DFL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dfl_req |=> !dfl_req); // R8
   AST_IINV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      iinv_req |=> !iinv_req); // R8
   AST_L2INV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      l2inv_req |=> !l2inv_req); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
endmodule

bind l2_enable_seq l2_enable_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .pf_bit    (feat_o[PF_BIT]),
   .en_bit    (feat_o[EN_BIT]),
   .dc_en     (dc_en_o),
   .ic_en     (ic_en_o),
   .dfl_req   (dc_flush_req_o),
   .iinv_req  (ic_inv_req_o),
   .l2inv_req (l2_inv_req_o),
   .done      (done_o)
);

// File: tb/test_l2_enable_seq.sv
module test_l2_enable_seq;
   // event codes recorded by the monitor
   localparam int EV_DFL = 1, EV_DC_OFF = 2, EV_IC_OFF = 3, EV_IINV = 4,
                  EV_L2INV = 5, EV_EN_ON = 6, EV_IC_ON = 7, EV_DC_ON = 8, EV_DONE = 9;
   localparam logic [31:0] PF_M = 32'h0100_0000;
   localparam logic [31:0] EN_M = 32'h0040_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] feat_in = '0;
   logic        dc_in = 1'b0, ic_in = 1'b0;
   logic [31:0] feat_o;
   logic        dc_o, ic_o, dfl_req, iinv_req, l2_req, done;
   logic [2:0]  resp = '0;
   logic [2:0]  spur = '0;
   int          lat[3] = '{2, 3, 4};
   int          cnt[3] = '{0, 0, 0};
   int          log_q[$];
   logic        mon_skip = 1'b1;
   logic        p_dc = 1'b0, p_ic = 1'b0, p_en = 1'b0;
   int          n_chk = 0, n_fail = 0, cyc = 0;

   always #2 clk = ~clk; // 250 MHz

   l2_enable_seq i_l2_enable_seq (
      .clk (clk), .rst_n (rst_n), .start_i (start), .feat_in_i (feat_in),
      .dc_en_in_i (dc_in), .ic_en_in_i (ic_in), .feat_o (feat_o),
      .dc_en_o (dc_o), .ic_en_o (ic_o), .dc_flush_req_o (dfl_req),
      .ic_inv_req_o (iinv_req), .l2_inv_req_o (l2_req),
      .dc_flush_done_i (resp[0] | spur[0]), .ic_inv_done_i (resp[1] | spur[1]),
      .l2_inv_done_i (resp[2] | spur[2]), .done_o (done)
   );

   // completion responders
   always @(negedge clk) begin
      logic [2:0] r;
      r = {l2_req, iinv_req, dfl_req};
      for (int k = 0; k < 3; k++) begin
         resp[k] <= 1'b0;
         if (r[k]) cnt[k] = lat[k];
         else if (cnt[k] > 0) begin
            cnt[k]--;
            if (cnt[k] == 0) resp[k] <= 1'b1;
         end
      end
   end

   // event monitor
   always @(negedge clk) begin
      if (!mon_skip) begin
         if (dfl_req)          log_q.push_back(EV_DFL);
         if (p_dc && !dc_o)    log_q.push_back(EV_DC_OFF);
         if (p_ic && !ic_o)    log_q.push_back(EV_IC_OFF);
         if (iinv_req)         log_q.push_back(EV_IINV);
         if (l2_req)           log_q.push_back(EV_L2INV);
         if (!p_en && feat_o[22]) log_q.push_back(EV_EN_ON);
         if (!p_ic && ic_o)    log_q.push_back(EV_IC_ON);
         if (!p_dc && dc_o)    log_q.push_back(EV_DC_ON);
         if (done)             log_q.push_back(EV_DONE);
      end
      mon_skip = 1'b0;
      p_dc = dc_o; p_ic = ic_o; p_en = feat_o[22];
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic chk_log(input string rq, input int exp_q[$]);
      chk(log_q.size() == exp_q.size(), rq, "event count", log_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
         chk(log_q[i] == exp_q[i], rq, $sformatf("event %0d", i), log_q[i], exp_q[i]);
   endtask

   task automatic kick(input logic [31:0] f, input logic d, input logic i);
      @(posedge clk); #1;
      feat_in = f; dc_in = d; ic_in = i; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      log_q.delete();
      mon_skip = 1'b1;
   endtask

   task automatic wait_done();
      for (int t = 0; t < 300; t++) begin
         @(negedge clk);
         if (done) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(feat_o == 0, "R1", "feature copy", feat_o, 0);
      chk(!dc_o && !ic_o, "R1", "L1 enables", {dc_o, ic_o}, 0);
      chk(!dfl_req && !iinv_req && !l2_req && !done, "R1", "req/done",
          {dfl_req, iinv_req, l2_req, done}, 0);
   endtask

   task automatic t_seq(input string rq, input logic [31:0] f, input logic d,
                        input logic i, input int exp_q[$]);
      kick(f, d, i);
      wait_done();
      chk_log(rq, exp_q);
      chk(feat_o == (f | PF_M | EN_M), "R2", {rq, " final feature"}, feat_o, f | PF_M | EN_M);
      chk(dc_o == d, rq, "final dc enable", dc_o, d);
      chk(ic_o == i, rq, "final ic enable", ic_o, i);
   endtask

   // stray completions and a second start while busy
   task automatic t_busy();
      lat[0] = 10;
      kick(32'h0000_00a5, 1'b1, 1'b1);
      for (int t = 0; t < 20 && log_q.size() == 0; t++) @(negedge clk);
      @(posedge clk); #1;
      spur = 3'b110;            // R8 completions nobody asked for
      start = 1'b1;             // R9 start while running
      feat_in = EN_M; dc_in = 1'b0; ic_in = 1'b0;
      @(posedge clk); #1;
      spur = 3'b000; start = 1'b0;
      repeat (3) @(negedge clk);
      chk(log_q.size() == 1, "R8", "events after stray done", log_q.size(), 1);
      chk(dc_o && ic_o, "R8", "L1 enables held", {dc_o, ic_o}, 2'b11);
      wait_done();
      chk_log("R9", '{EV_DFL, EV_DC_OFF, EV_IC_OFF, EV_IINV, EV_L2INV,
                      EV_EN_ON, EV_IC_ON, EV_DC_ON, EV_DONE});
      chk(feat_o == (32'h0000_00a5 | PF_M | EN_M), "R9", "feature unaffected by restart",
          feat_o, 32'h0000_00a5 | PF_M | EN_M);
      lat[0] = 2;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      // R4 R5 R6 R7: both caches on
      t_seq("R7", 32'h0000_0000, 1'b1, 1'b1, '{EV_DFL, EV_DC_OFF, EV_IC_OFF, EV_IINV,
            EV_L2INV, EV_EN_ON, EV_IC_ON, EV_DC_ON, EV_DONE});
      // R5: only instruction cache on
      t_seq("R5", 32'h1234_0000, 1'b0, 1'b1, '{EV_IC_OFF, EV_IINV, EV_L2INV, EV_EN_ON,
            EV_IC_ON, EV_DONE});
      // R4: only data cache on
      t_seq("R4", 32'h0000_ffff, 1'b1, 1'b0, '{EV_DFL, EV_DC_OFF, EV_L2INV, EV_EN_ON,
            EV_DC_ON, EV_DONE});
      // R6: both off
      t_seq("R6", 32'h0100_0000, 1'b0, 1'b0, '{EV_L2INV, EV_EN_ON, EV_DONE});
      // R3: already enabled, caches on, prefetch bit clear at start
      t_seq("R3", 32'h0040_0003, 1'b1, 1'b1, '{EV_DONE});
      t_busy();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule